// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This controller moves a device through six power modes: Off, Active, Modem-sleep, Light-sleep, Deep-sleep and Hibernation. It drives seven domain enables: the slow RTC timer, the 8 MHz internal oscillator, retention memory, RTC peripherals, the low-power coprocessor, the CPU clock, and the radio/baseband. It runs on the slow clock. It changes one domain per step. Enables are switched off from the top of a fixed order downwards, then switched on from the bottom upwards. Each step is `STEP_CYC` slow-clock cycles after the one before.

Software asks for a new mode through a valid/ready request port. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the CPU runs in a settled Active or Modem-sleep mode. At all other times the port applies back-pressure, and a held request waits until it can transfer. A transferred request that is not legal is dropped.

Wake inputs only have an effect in a settled sleep mode, and each sleep mode accepts its own set of them. A permitted wake starts the sequence back to Active. A wake-cause register keeps the first permitted wake until software clears it. Taking the power-up input low drops everything to Off at once.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `chip_pu` is low at a clock edge, the next state has `mode`=0 (Off), `dom_en`=0 and `busy`=0, whatever state came before. When Off with `chip_pu` high, the block sequences to Active with `restart` high.
- R2: Domain bits are: 0 RTC timer, 1 oscillator, 2 retention memory, 3 RTC peripherals, 4 coprocessor, 5 CPU clock, 6 radio. The settled enables are:
  - Active 0x7F
  - Modem-sleep 0x3F
  - Light-sleep 0x1F
  - Deep-sleep 0x1F
  - Hibernation 0x01
  - Off 0x00
- R3: During a sequence, at most one `dom_en` bit changes per edge, and a change happens every `STEP_CYC` cycles. Bits that must turn off go first, highest index first. Bits that must turn on follow, lowest index first.
- R4: `req_ready` is high exactly when `chip_pu` is high, `busy` is low and the mode is Active or Modem-sleep. The mode codes on `mode` and `req_mode` are 0 Off, 1 Active, 2 Modem-sleep, 3 Light-sleep, 4 Deep-sleep, 5 Hibernation.
- R5: A transferred request is ignored in three cases: its code is 0, 6 or 7; it names the current mode; or it names codes 3 to 5 while `wifi_en` is high.
- R6: In Light-sleep, the permitted wakes are `wake_in` bits 0 (MAC), 1 (SDIO host), 2 (RTC timer) and 4 (external interrupt). Bits 3 and 5 have no effect.
- R7: In Deep-sleep, the permitted wakes are bits 2 (RTC timer), 3 (RTC GPIO) and 5 (coprocessor). Bits 0, 1 and 4 have no effect.
- R8: In Hibernation, the permitted wakes are bits 2 and 3 only.
- R9: `restart` is high during a sequence to Active that starts from Off, Deep-sleep or Hibernation. It stays low for a wake from Light-sleep.
- R10: The first permitted wake is loaded into `wake_cause` as a one-hot value, choosing the lowest index when several arrive together. Only this happens while `wake_cause` is zero. After that the value holds until `cause_clr`, which clears it and takes priority over a new wake.
- R11: `busy` is high from the edge that starts a sequence until the edge after the enables reach the target. Meanwhile `mode` keeps showing the previous mode, and it updates at that final edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_pu | input | 1 | Power-up input; low forces Off |
| wifi_en | input | 1 | Wireless enabled; limits requests to Active/Modem-sleep |
| req_valid | input | 1 | Mode request valid |
| req_mode | input | 3 | Requested mode code |
| req_ready | output | 1 | Request can transfer |
| wake_in | input | 6 | Wake events (bit map in R6/R7) |
| cause_clr | input | 1 | Software write that clears the wake cause |
| dom_en | output | 7 | Domain enables (bit map in R2) |
| mode | output | 3 | Current settled mode |
| busy | output | 1 | Sequence in progress |
| restart | output | 1 | Reset-like restart in progress |
| wake_cause | output | 6 | Latched one-hot wake cause |

## Verification
The bench builds the block with `STEP_CYC`=2. This makes each step wait on the inter-step counter, which the default value of 1 reduces to a per-cycle step, so step spacing and off/on ordering are both observable. The run covers:
- every sleep mode, each tried with permitted and rejected wake bits;
- requests refused by the wireless rule;
- an Off request code;
- a power-up drop partway through a sequence.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int NDOM   = 7;
  localparam int NWAKE  = 6;
  localparam int MODE_W = 3;

  localparam int D_TIMER = 0;
  localparam int D_OSC   = 1;
  localparam int D_MEM   = 2;
  localparam int D_PER   = 3;
  localparam int D_COPRO = 4;
  localparam int D_CPU   = 5;
  localparam int D_RADIO = 6;

  localparam int W_MAC   = 0;
  localparam int W_SDIO  = 1;
  localparam int W_TIMER = 2;
  localparam int W_GPIO  = 3;
  localparam int W_EXT   = 4;
  localparam int W_COPRO = 5;

  typedef enum logic [MODE_W-1:0] {
    PM_OFF    = 3'd0,
    PM_ACTIVE = 3'd1,
    PM_MODEM  = 3'd2,
    PM_LIGHT  = 3'd3,
    PM_DEEP   = 3'd4,
    PM_HIBER  = 3'd5
  } pm_mode_e;

  function automatic logic [NDOM-1:0] dom_mask(pm_mode_e m);
    logic [NDOM-1:0] r;
    r = '0;
    case (m)
      PM_ACTIVE: r = '1;
      PM_MODEM: begin
        r = '1;
        r[D_RADIO] = 1'b0;
      end
      PM_LIGHT, PM_DEEP: begin
        r[D_TIMER] = 1'b1;
        r[D_OSC]   = 1'b1;
        r[D_MEM]   = 1'b1;
        r[D_PER]   = 1'b1;
        r[D_COPRO] = 1'b1;
      end
      PM_HIBER: r[D_TIMER] = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [NWAKE-1:0] wake_allow(pm_mode_e m);
    logic [NWAKE-1:0] r;
    r = '0;
    case (m)
      PM_LIGHT: begin
        r[W_MAC]   = 1'b1;
        r[W_SDIO]  = 1'b1;
        r[W_TIMER] = 1'b1;
        r[W_EXT]   = 1'b1;
      end
      PM_DEEP: begin
        r[W_TIMER] = 1'b1;
        r[W_GPIO]  = 1'b1;
        r[W_COPRO] = 1'b1;
      end
      PM_HIBER: begin
        r[W_TIMER] = 1'b1;
        r[W_GPIO]  = 1'b1;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic is_sleep(pm_mode_e m);
    return (m == PM_LIGHT) || (m == PM_DEEP) || (m == PM_HIBER);
  endfunction
endpackage

// File: rtl/pwr_wake_sel.sv
module pwr_wake_sel
  import pwr_seq_pkg::*;
#(
  parameter int NW = NWAKE
) (
  input  pm_mode_e         cur_mode,
  input  logic             armed,
  input  logic [NW-1:0]    wake_in,
  input  logic [NW-1:0]    allow,
  output logic             hit,
  output logic [NW-1:0]    pick
);
  logic [NW-1:0] live;
  logic          is_deep;

  assign is_deep = (cur_mode == PM_DEEP) || (cur_mode == PM_HIBER);
  assign live    = armed ? (wake_in & allow) : '0;
  assign hit     = |live;

  always_comb begin
    logic seen;
    seen = 1'b0;
    pick = '0;
    for (int i = 0; i < NW; i++) begin
      if (!seen && live[i]) begin
        pick[i] = 1'b1;
        seen    = 1'b1;
      end
    end
  end

  logic unused_deep;
  assign unused_deep = is_deep;
endmodule

// File: rtl/pwr_cause_reg.sv
module pwr_cause_reg #(
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hit,
  input  logic [NW-1:0] pick,
  output logic [NW-1:0] cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
    end else if (clr) begin
      cause <= '0;
    end else if (hit && (cause == '0)) begin
      cause <= pick;
    end
  end
endmodule

// File: rtl/pwr_dom_stepper.sv
module pwr_dom_stepper #(
  parameter int ND       = 7,
  parameter int STEP_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          run,
  input  logic [ND-1:0] tgt,
  output logic [ND-1:0] dom,
  output logic          match
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [ND-1:0] nxt;
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign match = (dom == tgt);
  assign tick  = (cnt_q == CW'(STEP_CYC - 1));

  always_comb begin
    logic [ND-1:0] down;
    logic [ND-1:0] up;
    logic          done;
    down = dom & ~tgt;
    up   = tgt & ~dom;
    nxt  = dom;
    done = 1'b0;
    for (int i = ND - 1; i >= 0; i--) begin
      if (!done && down[i]) begin
        nxt[i] = 1'b0;
        done   = 1'b1;
      end
    end
    for (int i = 0; i < ND; i++) begin
      if (!done && up[i]) begin
        nxt[i] = 1'b1;
        done   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom   <= '0;
      cnt_q <= '0;
    end else if (kill) begin
      dom   <= '0;
      cnt_q <= '0;
    end else if (run && !match) begin
      if (tick) begin
        dom   <= nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int STEP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_pu,
  input  logic              wifi_en,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  output logic              req_ready,
  input  logic [NWAKE-1:0]  wake_in,
  input  logic              cause_clr,
  output logic [NDOM-1:0]   dom_en,
  output logic [MODE_W-1:0] mode,
  output logic              busy,
  output logic              restart,
  output logic [NWAKE-1:0]  wake_cause
);
  pm_mode_e mode_q, tgt_q, rq;
  logic     busy_q, rst_q;
  logic     awake, legal, take, armed, hit, match;
  logic [NWAKE-1:0] pick;

  assign rq        = pm_mode_e'(req_mode);
  assign awake     = (mode_q == PM_ACTIVE) || (mode_q == PM_MODEM);
  assign req_ready = chip_pu && !busy_q && awake;
  assign take      = req_valid && req_ready && legal;
  assign armed     = chip_pu && !busy_q && is_sleep(mode_q);

  always_comb begin
    case (rq)
      PM_ACTIVE, PM_MODEM:         legal = (rq != mode_q);
      PM_LIGHT, PM_DEEP, PM_HIBER: legal = !wifi_en;
      default:                     legal = 1'b0;
    endcase
  end

  pwr_wake_sel #(.NW(NWAKE)) u_wake (
    .cur_mode (mode_q),
    .armed    (armed),
    .wake_in  (wake_in),
    .allow    (wake_allow(mode_q)),
    .hit      (hit),
    .pick     (pick)
  );

  pwr_cause_reg #(.NW(NWAKE)) u_cause (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cause_clr),
    .hit   (hit),
    .pick  (pick),
    .cause (wake_cause)
  );

  pwr_dom_stepper #(.ND(NDOM), .STEP_CYC(STEP_CYC)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .kill  (!chip_pu),
    .run   (busy_q),
    .tgt   (dom_mask(tgt_q)),
    .dom   (dom_en),
    .match (match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_OFF;
      tgt_q  <= PM_OFF;
      busy_q <= 1'b0;
      rst_q  <= 1'b0;
    end else if (!chip_pu) begin
      mode_q <= PM_OFF;
      tgt_q  <= PM_OFF;
      busy_q <= 1'b0;
      rst_q  <= 1'b0;
    end else if (busy_q) begin
      if (match) begin
        mode_q <= tgt_q;
        busy_q <= 1'b0;
        rst_q  <= 1'b0;
      end
    end else if (mode_q == PM_OFF) begin
      tgt_q  <= PM_ACTIVE;
      busy_q <= 1'b1;
      rst_q  <= 1'b1;
    end else if (take) begin
      tgt_q  <= rq;
      busy_q <= 1'b1;
    end else if (hit) begin
      tgt_q  <= PM_ACTIVE;
      busy_q <= 1'b1;
      rst_q  <= (mode_q == PM_DEEP) || (mode_q == PM_HIBER);
    end
  end

  assign mode    = mode_q;
  assign busy    = busy_q;
  assign restart = rst_q;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
  import pwr_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              chip_pu,
  input logic              req_ready,
  input logic              cause_clr,
  input logic [NDOM-1:0]   dom_en,
  input logic [MODE_W-1:0] mode,
  input logic              busy,
  input logic              restart,
  input logic [NWAKE-1:0]  wake_cause
);
  AST_PU_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_pu |=> (dom_en == '0 && mode == 3'd0 && !busy)); // R1

  AST_SETTLED_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dom_en == dom_mask(pm_mode_e'(mode))); // R2

  AST_HIBER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode == 3'd5) |-> (!dom_en[D_OSC] && !dom_en[D_COPRO] && !dom_en[D_MEM])); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    chip_pu |=> $countones(dom_en ^ $past(dom_en)) <= 1); // R3

  AST_READY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && (mode == 3'd1 || mode == 3'd2))); // R4

  AST_RESTART_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> busy); // R9

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_cause)); // R10

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cause != '0 && !cause_clr) |=> $stable(wake_cause)); // R10

  AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chip_pu) |=> ($stable(mode) || !busy)); // R11
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_pu    (chip_pu),
  .req_ready  (req_ready),
  .cause_clr  (cause_clr),
  .dom_en     (dom_en),
  .mode       (mode),
  .busy       (busy),
  .restart    (restart),
  .wake_cause (wake_cause)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int STEP  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_pu = 1'b0;
  logic       wifi_en = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic       req_ready;
  logic [5:0] wake_in = 6'd0;
  logic       cause_clr = 1'b0;
  logic [6:0] dom_en;
  logic [2:0] mode;
  logic       busy;
  logic       restart;
  logic [5:0] wake_cause;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwr_seq_ctrl #(.STEP_CYC(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_pu(chip_pu), .wifi_en(wifi_en),
    .req_valid(req_valid), .req_mode(req_mode), .req_ready(req_ready),
    .wake_in(wake_in), .cause_clr(cause_clr), .dom_en(dom_en), .mode(mode),
    .busy(busy), .restart(restart), .wake_cause(wake_cause)
  );

  // Reference model, written from the requirements
  int m_mode = 0, m_tgt = 0, m_busy = 0, m_rst = 0, m_dom = 0, m_cnt = 0, m_cause = 0;

  function automatic int want(int md);
    case (md)
      1: return 'h7F;
      2: return 'h3F;
      3, 4: return 'h1F;
      5: return 'h01;
      default: return 0;
    endcase
  endfunction

  function automatic int allowed(int md);
    case (md)
      3: return 'b010111;
      4: return 'b101100;
      5: return 'b001100;
      default: return 0;
    endcase
  endfunction

  function automatic int one_step(int cur, int tgt);
    for (int i = 6; i >= 0; i--)
      if (cur[i] && !tgt[i]) return cur & ~(1 << i);
    for (int i = 0; i <= 6; i++)
      if (!cur[i] && tgt[i]) return cur | (1 << i);
    return cur;
  endfunction

  function automatic int m_ready();
    return (chip_pu && !m_busy && (m_mode == 1 || m_mode == 2)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_tgt = 0; m_busy = 0; m_rst = 0; m_dom = 0; m_cnt = 0; m_cause = 0;
    end else begin
      int live, first, ok, rdy;
      rdy  = m_ready();
      live = (chip_pu && !m_busy) ? (int'(wake_in) & allowed(m_mode)) : 0;
      first = 0;
      for (int i = 0; i < 6; i++) if (first == 0 && live[i]) first = 1 << i;
      ok = 0;
      if (req_mode == 1 || req_mode == 2) ok = (int'(req_mode) != m_mode);
      else if (req_mode >= 3 && req_mode <= 5) ok = !wifi_en;
      if (cause_clr) m_cause = 0;
      else if (first != 0 && m_cause == 0) m_cause = first;
      if (!chip_pu) begin
        m_mode = 0; m_tgt = 0; m_busy = 0; m_rst = 0; m_dom = 0; m_cnt = 0;
      end else if (m_busy) begin
        if (m_dom == want(m_tgt)) begin
          m_mode = m_tgt; m_busy = 0; m_rst = 0; m_cnt = 0;
        end else if (m_cnt == STEP - 1) begin
          m_dom = one_step(m_dom, want(m_tgt)); m_cnt = 0;
        end else m_cnt++;
      end else if (m_mode == 0) begin
        m_tgt = 1; m_busy = 1; m_rst = 1;
      end else if (req_valid && rdy && ok) begin
        m_tgt = int'(req_mode); m_busy = 1;
      end else if (first != 0) begin
        m_rst = (m_mode == 4 || m_mode == 5) ? 1 : 0;
        m_tgt = 1; m_busy = 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      cyc++;
      chk("R3",  int'(dom_en),     m_dom,     "dom_en");
      chk("R11", int'(mode),       m_mode,    "mode");
      chk("R11", int'(busy),       m_busy,    "busy");
      chk("R9",  int'(restart),    m_rst,     "restart");
      chk("R10", int'(wake_cause), m_cause,   "wake_cause");
      chk("R4",  int'(req_ready),  m_ready(), "req_ready");
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  task automatic settle();
    repeat (40) @(negedge clk);
    #(CLK_P/4);
  endtask

  task automatic req(int md);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 3'(md);
    @(negedge clk);
    req_valid = 1'b0; req_mode = 3'd0;
  endtask

  task automatic wake(int bits);
    @(negedge clk);
    wake_in = 6'(bits);
    @(negedge clk);
    wake_in = 6'd0;
  endtask

  task automatic clear_cause();
    @(negedge clk);
    cause_clr = 1'b1;
    @(negedge clk);
    cause_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    chk("R1", int'(mode), 0, "off while pu low");
    chk("R1", int'(dom_en), 0, "domains off while pu low");

    @(negedge clk); chip_pu = 1'b1;
    @(negedge clk); #(CLK_P/4);
    chk("R9", int'(restart), 1, "restart on power-up");
    settle();
    chk("R2", int'(dom_en), 'h7F, "active domains");
    chk("R4", int'(req_ready), 1, "ready in active");

    wifi_en = 1'b1;
    req(3); settle();
    chk("R5", int'(mode), 1, "light refused with wifi");
    req(2); #(CLK_P/4);
    chk("R11", int'(mode), 1, "mode held while busy");
    chk("R11", int'(busy), 1, "busy after accept");
    settle();
    chk("R2", int'(dom_en), 'h3F, "modem domains");
    req(1); settle();
    wifi_en = 1'b0;
    req(0); settle();
    chk("R5", int'(mode), 1, "off code ignored");
    req(7); settle();
    chk("R5", int'(mode), 1, "code 7 ignored");

    req(3); settle();
    chk("R2", int'(dom_en), 'h1F, "light domains");
    chk("R4", int'(req_ready), 0, "no ready in light");
    wake('b101000); settle();
    chk("R6", int'(mode), 3, "gpio/copro ignored in light");
    wake('b000011); settle();
    chk("R6", int'(mode), 1, "mac wakes light");
    chk("R10", int'(wake_cause), 'b000001, "lowest wake wins");

    clear_cause(); #(CLK_P/4);
    chk("R10", int'(wake_cause), 0, "cause cleared");
    req(4); settle();
    chk("R2", int'(dom_en), 'h1F, "deep domains");
    wake('b010011); settle();
    chk("R7", int'(mode), 4, "mac/sdio/ext ignored in deep");
    wake('b100000); #(CLK_P/4);
    chk("R9", int'(restart), 1, "restart from deep");
    settle();
    chk("R7", int'(mode), 1, "copro wakes deep");
    chk("R10", int'(wake_cause), 'b100000, "copro cause");

    req(5); settle();
    chk("R2", int'(dom_en), 'h01, "hibernation domains");
    wake('b110011); settle();
    chk("R8", int'(mode), 5, "non-rtc wakes ignored in hibernation");
    wake('b000100); settle();
    chk("R8", int'(mode), 1, "timer wakes hibernation");
    chk("R10", int'(wake_cause), 'b100000, "cause held until cleared");

    req(5);
    repeat (4) @(negedge clk);
    chip_pu = 1'b0;
    repeat (2) @(negedge clk); #(CLK_P/4);
    chk("R1", int'(dom_en), 0, "pu drop mid-sequence");
    chk("R1", int'(mode), 0, "pu drop forces off");
    @(negedge clk); chip_pu = 1'b1;
    settle();
    chk("R1", int'(mode), 1, "power-up returns to active");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule